// File: doc/BRIEF.md
# Flash Opcode-Menu Command Sequencer

This block is a programmable command engine for a serial NOR flash. Firmware fills a table of eight opcode bytes and a per-entry type code, then seals the table. After that, the host starts a command by writing one control word. The word names a table entry by its index, sets the data length, and chooses whether to send a write-enable style prefix first.

The engine drives the flash pins in SPI mode 0. It sends the selected opcode and, when the entry's type asks for it, a 24-bit address. It then moves data between the flash and a shared 64-byte buffer, in the direction the entry's type gives.

When a prefix is requested, the engine runs an atomic sequence:
1. It sends the prefix in its own chip-select frame.
2. It sends the main command in a second frame.
3. It polls the flash status register until the write-in-progress flag drops.

Completion and the two error kinds are reported as sticky status bits in the control word.

Top module: `flash_menu_seq`

## Requirements
- R1: After reset, all four registers read zero, `spi_cs_n` is high and `spi_sclk` is low.
- R2: Menu entries 0 to 3 are bytes 0 to 3 of the word at offset 2, and entries 4 to 7 are bytes 0 to 3 of the word at offset 3. A start (control bit 9) sends the entry named by control bits 14:12 as the first byte of a chip-select frame.
- R3: The offset 1 word holds a 2-bit type for entry i at bits 16+2i. Bit 1 of the type means a 3-byte address follows the opcode, taken from `flash_addr` most significant byte first. Bit 0 of the type means the data direction is toward the flash.
- R4: When control bit 22 is set, a data phase follows with (bits 21:16)+1 bytes, from 1 to 64. Write-type entries send buffer bytes 0, 1, and so on. Read-type entries store the received bytes into buffer positions 0, 1, and so on. Without bit 22 there is no data phase.
- R5: Control bit 10 requests an atomic sequence. The prefix byte is taken from bits 7:0 of offset 1 when control bit 11 is 0, or from bits 15:8 when bit 11 is 1. It is sent alone in its own frame, chip select is raised, and then the main command follows in a new frame.
- R6: After the main frame of an atomic sequence, the engine sends 0x05 and reads one byte, in a new frame each time. It repeats until bit 0 of that byte reads 0, and only then reports done.
- R7: If POLL_MAX (default 8) polls in a row return bit 0 set, the engine stops polling and sets both the cycle-error bit (bit 3) and done (bit 2).
- R8: Status bit 0 reads 1 from an accepted start until the last frame ends. Done (bit 2) sets when the command ends. Bits 2, 3 and 4 are cleared by writing 1 to them.
- R9: Writing 1 to control bit 15 seals the table. Lock stays set until reset. After lock, writes to offsets 1, 2 and 3 leave them unchanged.
- R10: A start before lock sends nothing on the SPI pins and sets the access-error bit (bit 4).
- R11: A control write while a command is running is ignored. The running command and its readback fields are not changed, and no second frame set is issued.
- R12: SPI frames are mode 0, most significant bit first: `spi_sclk` is low whenever chip select is high, and the flash samples `spi_mosi` on rising `spi_sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| flash_addr | input | 24 | Shared flash address, captured at start |
| buf_idx | output | 6 | Shared data buffer byte index |
| buf_rdata | input | 8 | Buffer byte at `buf_idx` |
| buf_we | output | 1 | Buffer write strobe for read data |
| buf_wdata | output | 8 | Byte to store at `buf_idx` |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data toward flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
Two situations are hard to reach from the ports.

The first is the poll-limit path. The bench's flash model holds the write-in-progress flag for a programmable number of status polls. Setting that number far above POLL_MAX drives the engine into its error exit, while a count of two checks normal polling.

The second is a start request that arrives while a command is running. The bench starts a 64-byte read, which gives a long busy window. It then writes a different command with start set and checks that the frame log and the control readback still match the first command.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    localparam int MENU_N     = 8;
    localparam int IDX_W      = $clog2(MENU_N);
    localparam int OPC_W      = 8;
    localparam int BUF_BYTES  = 64;
    localparam int CNT_W      = $clog2(BUF_BYTES);
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int TYPE_LSB   = 16;

    // control word bit positions
    localparam int B_BUSY = 0;
    localparam int B_DONE = 2;
    localparam int B_CERR = 3;
    localparam int B_AERR = 4;
    localparam int B_GO   = 9;
    localparam int B_ATOM = 10;
    localparam int B_PSEL = 11;
    localparam int B_IDX  = 12;
    localparam int B_LOCK = 15;
    localparam int B_CNT  = 16;
    localparam int B_DEN  = 22;
    localparam int B_SMI  = 23;

    localparam logic [1:0] A_CTRL    = 2'd0;
    localparam logic [1:0] A_PTYPE   = 2'd1;
    localparam logic [1:0] A_MENU_LO = 2'd2;
    localparam logic [1:0] A_MENU_HI = 2'd3;

    localparam logic [OPC_W-1:0] OPC_STATUS = 8'h05;

    typedef struct packed {
        logic [31:0] menu_hi;
        logic [31:0] menu_lo;
        logic [31:0] ptype;
    } cfg_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             atomic;
        logic             psel;
        logic             den;
        logic [CNT_W-1:0] last;
    } req_t;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [OPC_W-1:0] prefix;
        logic             has_addr;
        logic             is_write;
        logic             den;
        logic             atomic;
        logic [CNT_W-1:0] last;
    } cmd_t;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE, S_GAP, S_OP, S_ADDR,
        S_DLOAD, S_DATA, S_DNEXT, S_POLL_OP, S_POLL_RD
    } state_t;

    typedef enum logic [1:0] { G_MAIN, G_POLL, G_FIN } gap_t;

    function automatic cmd_t decode_cmd(cfg_t c, req_t r);
        cmd_t        k;
        logic [63:0] menu;
        logic [1:0]  ty;
        menu       = {c.menu_hi, c.menu_lo};
        ty         = c.ptype[TYPE_LSB + 2*r.idx +: 2];
        k.opcode   = menu[r.idx*8 +: 8];
        k.prefix   = r.psel ? c.ptype[15:8] : c.ptype[7:0];
        k.has_addr = ty[1];
        k.is_write = ty[0];
        k.den      = r.den;
        k.atomic   = r.atomic;
        k.last     = r.last;
        return k;
    endfunction

endpackage

// File: rtl/ssq_shift.sv
module ssq_shift #(
    parameter int HALF_PER = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int HW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam logic [HW-1:0] H_LAST = HW'(HALF_PER - 1);

    logic          active;
    logic [HW-1:0] hcnt;
    logic [2:0]    bitn;
    logic [7:0]    sr;
    logic [7:0]    rx;
    logic          sclk_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            hcnt   <= '0;
            bitn   <= '0;
            sr     <= '0;
            rx     <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sr     <= tx_byte;
                    hcnt   <= '0;
                    bitn   <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (hcnt == H_LAST) begin
                hcnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx     <= {rx[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sr   <= {sr[6:0], 1'b0};
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = sr[7];
    assign done    = done_q;
    assign rx_byte = rx;
endmodule

// File: rtl/ssq_regs.sv
module ssq_regs
    import ssq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        seq_busy,
    input  logic        done_set,
    input  logic        cerr_set,
    output logic        go_pulse,
    output req_t        req,
    output cfg_t        cfg,
    output logic        locked
);
    localparam int MENU_WORDS = MENU_N / 4;

    logic        lock_q, done_q, cerr_q, aerr_q, smi_q;
    req_t        req_q;
    logic [31:0] ptype_q;
    logic [31:0] menu_q [MENU_WORDS];
    logic        ctrl_wr;
    logic        start_req;
    req_t        wreq;

    assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL) && !seq_busy;
    assign start_req = ctrl_wr && reg_wdata[B_GO];
    assign go_pulse  = start_req && lock_q;

    always_comb begin
        wreq.idx    = reg_wdata[B_IDX +: IDX_W];
        wreq.atomic = reg_wdata[B_ATOM];
        wreq.psel   = reg_wdata[B_PSEL];
        wreq.den    = reg_wdata[B_DEN];
        wreq.last   = reg_wdata[B_CNT +: CNT_W];
    end
    assign req = wreq;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            done_q  <= 1'b0;
            cerr_q  <= 1'b0;
            aerr_q  <= 1'b0;
            smi_q   <= 1'b0;
            req_q   <= '0;
            ptype_q <= '0;
        end else begin
            if (ctrl_wr) begin
                req_q <= wreq;
                smi_q <= reg_wdata[B_SMI];
                if (reg_wdata[B_LOCK]) lock_q <= 1'b1;
            end
            done_q <= done_set | (done_q & ~(ctrl_wr & reg_wdata[B_DONE]));
            cerr_q <= cerr_set | (cerr_q & ~(ctrl_wr & reg_wdata[B_CERR]));
            aerr_q <= (start_req & ~lock_q) |
                      (aerr_q & ~(ctrl_wr & reg_wdata[B_AERR]));
            if (reg_wr && reg_addr == A_PTYPE && !lock_q) ptype_q <= reg_wdata;
        end
    end

    for (genvar g = 0; g < MENU_WORDS; g++) begin : g_menu
        always_ff @(posedge clk) begin
            if (rst) begin
                menu_q[g] <= '0;
            end else if (reg_wr && !lock_q && reg_addr == (A_MENU_LO + 2'(g))) begin
                menu_q[g] <= reg_wdata;
            end
        end
    end

    assign cfg.menu_lo = menu_q[0];
    assign cfg.menu_hi = menu_q[1];
    assign cfg.ptype   = ptype_q;
    assign locked      = lock_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_BUSY]            = seq_busy;
                reg_rdata[B_DONE]            = done_q;
                reg_rdata[B_CERR]            = cerr_q;
                reg_rdata[B_AERR]            = aerr_q;
                reg_rdata[B_ATOM]            = req_q.atomic;
                reg_rdata[B_PSEL]            = req_q.psel;
                reg_rdata[B_IDX +: IDX_W]    = req_q.idx;
                reg_rdata[B_LOCK]            = lock_q;
                reg_rdata[B_CNT +: CNT_W]    = req_q.last;
                reg_rdata[B_DEN]             = req_q.den;
                reg_rdata[B_SMI]             = smi_q;
            end
            A_PTYPE:   reg_rdata = ptype_q;
            A_MENU_LO: reg_rdata = menu_q[0];
            default:   reg_rdata = menu_q[1];
        endcase
    end
endmodule

// File: rtl/ssq_seq.sv
module ssq_seq
    import ssq_pkg::*;
#(
    parameter int GAP_CYC  = 2,
    parameter int POLL_MAX = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_pulse,
    input  req_t              req,
    input  cfg_t              cfg,
    input  logic [ADDR_W-1:0] flash_addr,
    output logic [CNT_W-1:0]  buf_idx,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    output logic              cs_n,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx,
    output logic              busy,
    output logic              done_set,
    output logic              cerr_set
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int PW = $clog2(POLL_MAX + 1);
    localparam int AW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [GW-1:0] G_END = GW'(GAP_CYC - 1);
    localparam logic [PW-1:0] P_END = PW'(POLL_MAX - 1);
    localparam logic [AW-1:0] A_END = AW'(ADDR_BYTES - 1);

    state_t            st;
    gap_t              gap_to;
    cmd_t              cmd_q, cmd_new;
    logic [ADDR_W-1:0] addr_q;
    logic [AW-1:0]     abyte;
    logic [CNT_W-1:0]  dcnt;
    logic [GW-1:0]     gcnt;
    logic [PW-1:0]     pcnt;
    logic              cs_n_q, start_q, we_q, done_q, cerr_q, cerr_pend;
    logic [7:0]        tx_q, wdata_q;

    assign cmd_new = decode_cmd(cfg, req);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            gap_to    <= G_FIN;
            cmd_q     <= '0;
            addr_q    <= '0;
            abyte     <= '0;
            dcnt      <= '0;
            gcnt      <= '0;
            pcnt      <= '0;
            cs_n_q    <= 1'b1;
            start_q   <= 1'b0;
            we_q      <= 1'b0;
            done_q    <= 1'b0;
            cerr_q    <= 1'b0;
            cerr_pend <= 1'b0;
            tx_q      <= '0;
            wdata_q   <= '0;
        end else begin
            start_q <= 1'b0;
            we_q    <= 1'b0;
            done_q  <= 1'b0;
            cerr_q  <= 1'b0;
            case (st)
                S_IDLE: if (go_pulse) begin
                    cmd_q     <= cmd_new;
                    addr_q    <= flash_addr;
                    dcnt      <= '0;
                    pcnt      <= '0;
                    abyte     <= '0;
                    cerr_pend <= 1'b0;
                    cs_n_q    <= 1'b0;
                    start_q   <= 1'b1;
                    if (cmd_new.atomic) begin
                        tx_q <= cmd_new.prefix;
                        st   <= S_PRE;
                    end else begin
                        tx_q <= cmd_new.opcode;
                        st   <= S_OP;
                    end
                end
                S_PRE: if (sh_done) begin
                    cs_n_q <= 1'b1;
                    gcnt   <= '0;
                    gap_to <= G_MAIN;
                    st     <= S_GAP;
                end
                S_GAP: begin
                    if (gcnt == G_END) begin
                        gcnt <= '0;
                        case (gap_to)
                            G_MAIN: begin
                                cs_n_q  <= 1'b0;
                                start_q <= 1'b1;
                                tx_q    <= cmd_q.opcode;
                                st      <= S_OP;
                            end
                            G_POLL: begin
                                cs_n_q  <= 1'b0;
                                start_q <= 1'b1;
                                tx_q    <= OPC_STATUS;
                                st      <= S_POLL_OP;
                            end
                            default: begin
                                done_q <= 1'b1;
                                cerr_q <= cerr_pend;
                                st     <= S_IDLE;
                            end
                        endcase
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                S_OP: if (sh_done) begin
                    if (cmd_q.has_addr) begin
                        start_q <= 1'b1;
                        tx_q    <= addr_q[ADDR_W-1 -: 8];
                        addr_q  <= {addr_q[ADDR_W-9:0], 8'h00};
                        abyte   <= '0;
                        st      <= S_ADDR;
                    end else if (cmd_q.den) begin
                        st <= S_DLOAD;
                    end else begin
                        cs_n_q <= 1'b1;
                        gcnt   <= '0;
                        gap_to <= cmd_q.atomic ? G_POLL : G_FIN;
                        st     <= S_GAP;
                    end
                end
                S_ADDR: if (sh_done) begin
                    if (abyte != A_END) begin
                        abyte   <= abyte + 1'b1;
                        start_q <= 1'b1;
                        tx_q    <= addr_q[ADDR_W-1 -: 8];
                        addr_q  <= {addr_q[ADDR_W-9:0], 8'h00};
                    end else if (cmd_q.den) begin
                        st <= S_DLOAD;
                    end else begin
                        cs_n_q <= 1'b1;
                        gcnt   <= '0;
                        gap_to <= cmd_q.atomic ? G_POLL : G_FIN;
                        st     <= S_GAP;
                    end
                end
                S_DLOAD: begin
                    start_q <= 1'b1;
                    tx_q    <= cmd_q.is_write ? buf_rdata : 8'h00;
                    st      <= S_DATA;
                end
                S_DATA: if (sh_done) begin
                    we_q    <= !cmd_q.is_write;
                    wdata_q <= sh_rx;
                    st      <= S_DNEXT;
                end
                S_DNEXT: begin
                    if (dcnt == cmd_q.last) begin
                        cs_n_q <= 1'b1;
                        gcnt   <= '0;
                        gap_to <= cmd_q.atomic ? G_POLL : G_FIN;
                        st     <= S_GAP;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                        st   <= S_DLOAD;
                    end
                end
                S_POLL_OP: if (sh_done) begin
                    start_q <= 1'b1;
                    tx_q    <= 8'h00;
                    st      <= S_POLL_RD;
                end
                S_POLL_RD: if (sh_done) begin
                    cs_n_q <= 1'b1;
                    gcnt   <= '0;
                    st     <= S_GAP;
                    if (!sh_rx[0]) begin
                        gap_to <= G_FIN;
                    end else if (pcnt == P_END) begin
                        gap_to    <= G_FIN;
                        cerr_pend <= 1'b1;
                    end else begin
                        pcnt   <= pcnt + 1'b1;
                        gap_to <= G_POLL;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy      = (st != S_IDLE);
    assign cs_n      = cs_n_q;
    assign sh_start  = start_q;
    assign sh_tx     = tx_q;
    assign buf_idx   = dcnt;
    assign buf_we    = we_q;
    assign buf_wdata = wdata_q;
    assign done_set  = done_q;
    assign cerr_set  = cerr_q;
endmodule

// File: rtl/flash_menu_seq.sv
module flash_menu_seq
    import ssq_pkg::*;
#(
    parameter int HALF_PER = 2,
    parameter int GAP_CYC  = 2,
    parameter int POLL_MAX = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [ADDR_W-1:0]   flash_addr,
    output logic [CNT_W-1:0]    buf_idx,
    input  logic [7:0]          buf_rdata,
    output logic                buf_we,
    output logic [7:0]          buf_wdata,
    output logic                spi_sclk,
    output logic                spi_cs_n,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    logic       seq_busy, done_set, cerr_set, go_pulse, locked;
    req_t       req;
    cfg_t       cfg;
    logic       sh_start, sh_done;
    logic [7:0] sh_tx, sh_rx;

    ssq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .seq_busy  (seq_busy),
        .done_set  (done_set),
        .cerr_set  (cerr_set),
        .go_pulse  (go_pulse),
        .req       (req),
        .cfg       (cfg),
        .locked    (locked)
    );

    ssq_seq #(.GAP_CYC(GAP_CYC), .POLL_MAX(POLL_MAX)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .go_pulse   (go_pulse),
        .req        (req),
        .cfg        (cfg),
        .flash_addr (flash_addr),
        .buf_idx    (buf_idx),
        .buf_rdata  (buf_rdata),
        .buf_we     (buf_we),
        .buf_wdata  (buf_wdata),
        .cs_n       (spi_cs_n),
        .sh_start   (sh_start),
        .sh_tx      (sh_tx),
        .sh_done    (sh_done),
        .sh_rx      (sh_rx),
        .busy       (seq_busy),
        .done_set   (done_set),
        .cerr_set   (cerr_set)
    );

    ssq_shift #(.HALF_PER(HALF_PER)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );
endmodule

// File: rtl/flash_menu_seq_chk.sv
module flash_menu_seq_chk
    import ssq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        spi_cs_n,
    input logic        spi_sclk,
    input logic        seq_busy,
    input logic        go_pulse,
    input logic        done_set,
    input logic        locked,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input cfg_t        cfg
);
    assert_sclk_idle_R12: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    assert_cs_in_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> seq_busy);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_set |-> !seq_busy);

    assert_no_go_unlocked_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[B_GO] && !locked && !seq_busy)
        |=> (spi_cs_n && !seq_busy));

    assert_go_idle_only_R11: assert property (@(posedge clk) disable iff (rst)
        go_pulse |-> !seq_busy);

    assert_busy_from_go_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_busy) |-> $past(go_pulse));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> $stable(cfg));
endmodule

bind flash_menu_seq flash_menu_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .seq_busy  (seq_busy),
    .go_pulse  (go_pulse),
    .done_set  (done_set),
    .locked    (locked),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg       (cfg)
);

// File: tb/sim_flash_menu_seq.sv
module sim_flash_menu_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [23:0] flash_addr;
    logic [5:0]  buf_idx;
    logic [7:0]  buf_rdata;
    logic        buf_we;
    logic [7:0]  buf_wdata;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int failures = 0;

    logic [7:0] bmem [64];
    logic [7:0] fr [16][80];
    int         fr_len [16];
    int         nfr = 0;
    int         bitc = 0;
    int         bytec = 0;
    int         wip_left = 0;
    logic [7:0] shreg = 8'h00;
    logic [7:0] cur_op = 8'h00;
    logic [7:0] rsp;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_menu_seq u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flash_addr(flash_addr),
        .buf_idx(buf_idx), .buf_rdata(buf_rdata), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // shared buffer
    assign buf_rdata = bmem[buf_idx];
    always @(posedge clk) if (buf_we) bmem[buf_idx] <= buf_wdata;

    // flash model: logs frames, answers reads with 0xA0+byte number,
    // answers status polls with WIP while wip_left > 0
    assign rsp = (bytec == 0) ? 8'h00 :
                 (cur_op == 8'h05) ? {7'b0, (wip_left > 0)} : 8'(8'hA0 + bytec);
    assign spi_miso = rsp[3'(7 - bitc)];

    always @(negedge spi_cs_n) begin
        bitc  = 0;
        bytec = 0;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        shreg = {shreg[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            if (nfr < 16 && bytec < 80) fr[nfr][bytec] = shreg;
            if (bytec == 0) cur_op = shreg;
            bytec++;
            bitc = 0;
        end
    end

    always @(posedge spi_cs_n) if (bytec > 0) begin
        if (nfr < 16) fr_len[nfr] = bytec;
        if (cur_op == 8'h05 && wip_left > 0) wip_left--;
        nfr++;
        bytec = 0;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd0, v);
            if (!v[0]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    // control word built from the bit positions in the requirements
    function automatic logic [31:0] ctl(int idx, bit go, bit atom, bit psel,
                                        bit den, int last);
        logic [31:0] w = '0;
        w[9]     = go;
        w[10]    = atom;
        w[11]    = psel;
        w[14:12] = 3'(idx);
        w[21:16] = 6'(last);
        w[22]    = den;
        return w;
    endfunction

    task automatic run(logic [31:0] w);
        nfr = 0;
        wr(2'd0, w);
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register reset value", v, 32'h0);
        end
        chk("R1 cs_n idle high", {31'b0, spi_cs_n}, 32'h1);
        chk("R1 sclk idle low", {31'b0, spi_sclk}, 32'h0);
    endtask

    task automatic t_unlocked();
        logic [31:0] v;
        wr(2'd2, 32'h0203019F);
        wr(2'd3, 32'h05500620);
        wr(2'd1, 32'h16E45006);
        run(ctl(0, 1, 0, 0, 0, 0));
        chk("R10 no frame before lock", 32'(nfr), 32'h0);
        rd(2'd0, v);
        chk("R10 access error set", {31'b0, v[4]}, 32'h1);
        wr(2'd0, 32'h10);
        rd(2'd0, v);
        chk("R8 access error W1C", {31'b0, v[4]}, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(2'd0, 32'h8000);
        wr(2'd2, 32'hFFFFFFFF);
        wr(2'd1, 32'h0);
        rd(2'd2, v);
        chk("R9 menu word unchanged after lock", v, 32'h0203019F);
        rd(2'd1, v);
        chk("R9 prefix/type unchanged after lock", v, 32'h16E45006);
        rd(2'd0, v);
        chk("R9 lock bit reads 1", {31'b0, v[15]}, 32'h1);
    endtask

    task automatic t_read_noaddr();
        logic [31:0] v;
        run(ctl(0, 1, 0, 0, 1, 2));
        chk("R2 one frame", 32'(nfr), 32'h1);
        chk("R2 opcode entry 0", {24'b0, fr[0][0]}, 32'h9F);
        chk("R4 frame length 1+3", 32'(fr_len[0]), 32'd4);
        chk("R4 buffer[0]", {24'b0, bmem[0]}, 32'hA1);
        chk("R4 buffer[2]", {24'b0, bmem[2]}, 32'hA3);
        chk("R12 mode0 msb first decoded", {24'b0, fr[0][0]}, 32'h9F);
        rd(2'd0, v);
        chk("R8 done after read", {31'b0, v[2]}, 32'h1);
        wr(2'd0, 32'h4);
        rd(2'd0, v);
        chk("R8 done W1C", {31'b0, v[2]}, 32'h0);
    endtask

    task automatic t_read_addr();
        flash_addr = 24'h123456;
        run(ctl(2, 1, 0, 0, 1, 3));
        chk("R3 opcode entry 2", {24'b0, fr[0][0]}, 32'h03);
        chk("R3 address msb", {24'b0, fr[0][1]}, 32'h12);
        chk("R3 address mid", {24'b0, fr[0][2]}, 32'h34);
        chk("R3 address lsb", {24'b0, fr[0][3]}, 32'h56);
        chk("R4 frame length 4+4", 32'(fr_len[0]), 32'd8);
        chk("R4 buffer[3] after address", {24'b0, bmem[3]}, 32'hA7);
    endtask

    task automatic t_write_addr();
        bmem[0] = 8'h11;
        bmem[1] = 8'h22;
        flash_addr = 24'hABCDEF;
        run(ctl(3, 1, 0, 0, 1, 1));
        chk("R2 opcode entry 3", {24'b0, fr[0][0]}, 32'h02);
        chk("R3 write address msb", {24'b0, fr[0][1]}, 32'hAB);
        chk("R4 write data byte 0", {24'b0, fr[0][4]}, 32'h11);
        chk("R4 write data byte 1", {24'b0, fr[0][5]}, 32'h22);
        chk("R4 write frame length", 32'(fr_len[0]), 32'd6);
        chk("R4 write leaves buffer", {24'b0, bmem[0]}, 32'h11);
    endtask

    task automatic t_atomic_erase();
        logic [31:0] v;
        flash_addr = 24'h010000;
        wip_left = 2;
        run(ctl(4, 1, 1, 0, 0, 0));
        chk("R5 frame count prefix+main+3 polls", 32'(nfr), 32'd5);
        chk("R5 prefix byte0 alone", {24'b0, fr[0][0]}, 32'h06);
        chk("R5 prefix frame length", 32'(fr_len[0]), 32'd1);
        chk("R2 opcode entry 4", {24'b0, fr[1][0]}, 32'h20);
        chk("R3 erase frame length", 32'(fr_len[1]), 32'd4);
        chk("R6 poll opcode", {24'b0, fr[4][0]}, 32'h05);
        chk("R6 poll frame length", 32'(fr_len[4]), 32'd2);
        rd(2'd0, v);
        chk("R6 done set", {31'b0, v[2]}, 32'h1);
        chk("R7 no cycle error", {31'b0, v[3]}, 32'h0);
        wr(2'd0, 32'h1C);
    endtask

    task automatic t_atomic_psel();
        wip_left = 0;
        run(ctl(5, 1, 1, 1, 0, 0));
        chk("R5 prefix byte1 selected", {24'b0, fr[0][0]}, 32'h50);
        chk("R2 opcode entry 5", {24'b0, fr[1][0]}, 32'h06);
        chk("R3 no address for type1", 32'(fr_len[1]), 32'd1);
        chk("R6 single poll", 32'(nfr), 32'd3);
        wr(2'd0, 32'h1C);
    endtask

    task automatic t_poll_limit();
        logic [31:0] v;
        wip_left = 100;
        run(ctl(6, 1, 1, 0, 0, 0));
        chk("R7 polls stop at limit 8", 32'(nfr), 32'd10);
        rd(2'd0, v);
        chk("R7 cycle error set", {31'b0, v[3]}, 32'h1);
        chk("R7 done set with error", {31'b0, v[2]}, 32'h1);
        wr(2'd0, 32'h1C);
        rd(2'd0, v);
        chk("R8 error and done W1C", {29'b0, v[4:2]}, 32'h0);
        wip_left = 0;
    endtask

    task automatic t_busy_go();
        logic [31:0] v;
        flash_addr = 24'h000100;
        nfr = 0;
        wr(2'd0, ctl(2, 1, 0, 0, 1, 63));
        repeat (20) @(negedge clk);
        rd(2'd0, v);
        chk("R8 busy during command", {31'b0, v[0]}, 32'h1);
        wr(2'd0, ctl(0, 1, 1, 1, 0, 5));
        wait_idle();
        chk("R11 one frame only", 32'(nfr), 32'h1);
        chk("R11 original opcode", {24'b0, fr[0][0]}, 32'h03);
        chk("R4 max length frame", 32'(fr_len[0]), 32'd68);
        chk("R4 buffer[63]", {24'b0, bmem[63]}, 32'hE3);
        rd(2'd0, v);
        chk("R11 readback index kept", {29'b0, v[14:12]}, 32'd2);
        chk("R11 readback count kept", {26'b0, v[21:16]}, 32'd63);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) bmem[i] = 8'h00;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        flash_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unlocked();
        t_lock();
        t_read_noaddr();
        t_read_addr();
        t_write_addr();
        t_atomic_erase();
        t_atomic_psel();
        t_poll_limit();
        t_busy_go();
        summary();
        $finish;
    end
endmodule